// File: doc/BRIEF.md
# Long Branch Decode and Execute Unit

This unit carries out one long IP-relative branch or call when given a 128-bit instruction bundle. A single-cycle start strobe presents the bundle, the current instruction pointer and slot index, the 64-entry predicate file, and three status bits: address translation on, branch-trace enable and single-step enable. One cycle later the unit returns its results.

The unit first checks that it may run at all. The bundle template must be the long-immediate form and the branch must sit in slot 1. The opcode must be a long branch or a long call. If any of these checks fails, the unit reports an illegal operation and changes nothing.

When the qualifying predicate is false, the unit moves to the next bundle. When it is true, the unit jumps to the current IP plus a 64-bit offset. That offset is gathered from four separate fields in both halves of the bundle. A long call also writes a return address into one of eight branch registers. The unit then checks the new IP against the unimplemented-address masks and reports at most one fault or trap, chosen by a fixed priority.

Top module: `long_branch_unit`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `done`, `illegal_op`, `update`, `taken`, `br_we` and `exc_code` are 0.
- R2: `done` and the other results appear in the cycle right after a cycle with `start` high. `done`, `illegal_op`, `update`, `taken` and `br_we` are high for that one cycle only.
- R3: The unit accepts a bundle only when `cur_slot` is 1 and `bundle[4:1]` is 4'b0010. Bit 0 is a don't-care. Any other case gives `illegal_op`.
- R4: The opcode is `bundle[127:124]`, the branch-register field is `bundle[95:93]` and the predicate index is `bundle[92:87]`. Opcode 4'hC is a branch and is legal only when the register field is 0. Opcode 4'hD is a call. Every other opcode gives `illegal_op`.
- R5: Offset bit 63 comes from `bundle[123]`. Offset bits [62:40] come from `bundle[86:64]`. Offset bits [39:24] come from `bundle[63:48]`. Offset bits [23:4] come from `bundle[119:100]`. Offset bits [3:0] are 0.
- R6: When the selected predicate is 0, `next_ip` = `cur_ip` + 16 and `next_slot` = 0. In this case `update` is 1, and `taken`, `br_we` and `exc_code` are all 0.
- R7: When the selected predicate is 1, `next_ip` = `cur_ip` + offset, `next_slot` = 0, and `update` and `taken` are both 1.
- R8: A taken call sets `br_we`, with `br_sel` equal to the register field and `br_data` = `cur_ip` + 16. A branch never sets `br_we`.
- R9: In physical mode (`xlate_on` = 0), the target is bad if any bit of the target under `phys_mask` is 1.
- R10: In virtual mode (`xlate_on` = 1), the target is bad unless the target bits under `virt_mask` are all 0 or all 1.
- R11: `exc_code` reports only on a taken branch or call, using this priority: 1 for a bad target, else 2 when branch trace is on, else 3 when single step is on, else 0.
- R12: When `illegal_op` is set, `update`, `taken` and `br_we` are 0 and `exc_code` is 0, whatever the status bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe |
| bundle | input | 128 | Instruction bundle |
| cur_ip | input | 64 | Address of the current bundle |
| cur_slot | input | 2 | Current slot index |
| pred | input | 64 | Predicate register file |
| phys_mask | input | 64 | Unimplemented physical-address bits |
| virt_mask | input | 64 | Unimplemented virtual-address bits plus the top implemented bit |
| xlate_on | input | 1 | Address translation enabled |
| trace_br | input | 1 | Branch-trace enable |
| step_en | input | 1 | Single-step enable |
| done | output | 1 | Results valid |
| illegal_op | output | 1 | Bundle is not an acceptable long branch or call |
| update | output | 1 | `next_ip` and `next_slot` are to be committed |
| taken | output | 1 | Predicate was true and the jump was made |
| next_ip | output | 64 | New instruction pointer |
| next_slot | output | 2 | New slot index |
| br_we | output | 1 | Branch-register write enable |
| br_sel | output | 3 | Branch register to write |
| br_data | output | 64 | Return address to write |
| exc_code | output | 2 | 0 none, 1 bad-address fault, 2 taken-branch trap, 3 trace trap |

## Verification
The bench builds the unit with its default parameters: a 64-entry predicate file, eight branch registers and a 16-byte bundle step. With these values, every predicate index and every branch-register number that the bundle fields can encode is a real target.

Because the masks are inputs, the bench picks them itself. It uses 16 unimplemented physical bits and a 13-bit virtual mask that ends at bit 51. This makes it possible to hit the exact edges of each check: a target that sets bit 48, a sign-extended negative target, and a target that sets only the top implemented bit.

// File: rtl/long_branch_unit.sv
module long_branch_unit #(
  parameter int PRED_N = 64,
  parameter int BR_N = 8,
  parameter int STEP_BYTES = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [127:0] bundle,
  input  logic [63:0]  cur_ip,
  input  logic [1:0]   cur_slot,
  input  logic [63:0]  pred,
  input  logic [63:0]  phys_mask,
  input  logic [63:0]  virt_mask,
  input  logic         xlate_on,
  input  logic         trace_br,
  input  logic         step_en,
  output logic         done,
  output logic         illegal_op,
  output logic         update,
  output logic         taken,
  output logic [63:0]  next_ip,
  output logic [1:0]   next_slot,
  output logic         br_we,
  output logic [2:0]   br_sel,
  output logic [63:0]  br_data,
  output logic [1:0]   exc_code
);
  localparam int QP_W = $clog2(PRED_N);
  localparam int SEL_W = $clog2(BR_N);
  localparam logic [1:0] EXC_NONE = 2'd0;
  localparam logic [1:0] EXC_ADDR = 2'd1;
  localparam logic [1:0] EXC_BRTRAP = 2'd2;
  localparam logic [1:0] EXC_STEP = 2'd3;

  logic [63:0] hi, lo;
  assign hi = bundle[127:64];
  assign lo = bundle[63:0];

  logic [3:0]       opc;
  logic [SEL_W-1:0] rsel;
  logic [QP_W-1:0]  qp;
  assign opc  = hi[63:60];
  assign rsel = hi[29 +: SEL_W];
  assign qp   = hi[23 +: QP_W];

  logic shape_ok, is_br, is_call, legal, qp_true;
  assign shape_ok = (cur_slot == 2'd1) && ((lo[4:0] & 5'h1E) == 5'h04);
  assign is_br    = (opc == 4'hC) && (rsel == '0);
  assign is_call  = (opc == 4'hD);
  assign legal    = shape_ok && (is_br || is_call);
  assign qp_true  = pred[qp];

  logic [63:0] rel, seq_ip, tgt;
  assign rel    = {hi[59], hi[22:0], lo[63:48], hi[55:36], 4'b0000};
  assign seq_ip = cur_ip + 64'(STEP_BYTES);
  assign tgt    = cur_ip + rel;

  logic [63:0] vbits;
  logic phys_bad, virt_bad, addr_bad;
  assign vbits    = tgt & virt_mask;
  assign phys_bad = |(tgt & phys_mask);
  assign virt_bad = (vbits != '0) && (vbits != virt_mask);
  assign addr_bad = xlate_on ? virt_bad : phys_bad;

  logic [1:0] exc_n;
  always_comb begin
    if (addr_bad)      exc_n = EXC_ADDR;
    else if (trace_br) exc_n = EXC_BRTRAP;
    else if (step_en)  exc_n = EXC_STEP;
    else               exc_n = EXC_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      illegal_op <= 1'b0;
      update     <= 1'b0;
      taken      <= 1'b0;
      br_we      <= 1'b0;
      exc_code   <= EXC_NONE;
      next_ip    <= '0;
      next_slot  <= '0;
      br_sel     <= '0;
      br_data    <= '0;
    end else begin
      done       <= start;
      illegal_op <= start && !legal;
      update     <= start && legal;
      taken      <= start && legal && qp_true;
      br_we      <= start && legal && qp_true && is_call;
      exc_code   <= (start && legal && qp_true) ? exc_n : EXC_NONE;
      if (start && legal) begin
        next_ip   <= qp_true ? tgt : seq_ip;
        next_slot <= 2'd0;
        br_sel    <= 3'(rsel);
        br_data   <= seq_ip;
      end
    end
  end
endmodule

// File: rtl/long_branch_unit_chk.sv
module long_branch_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [63:0] cur_ip,
  input logic        done,
  input logic        illegal_op,
  input logic        update,
  input logic        taken,
  input logic [63:0] next_ip,
  input logic [1:0]  next_slot,
  input logic        br_we,
  input logic [63:0] br_data,
  input logic [1:0]  exc_code
);
  p_done_follows_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done && !update && !br_we && !illegal_op);
  p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op |-> !update && !taken && !br_we && exc_code == 2'd0);
  p_write_needs_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    br_we |-> taken && update && br_data == $past(cur_ip) + 64'd16);
  p_exc_needs_taken_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code != 2'd0 |-> taken);
  p_skip_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    update && !taken |-> next_ip == $past(cur_ip) + 64'd16 && next_slot == 2'd0);
  p_slot_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> next_slot == 2'd0 && update);
endmodule

bind long_branch_unit long_branch_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cur_ip(cur_ip), .done(done),
  .illegal_op(illegal_op), .update(update), .taken(taken), .next_ip(next_ip),
  .next_slot(next_slot), .br_we(br_we), .br_data(br_data), .exc_code(exc_code)
);

// File: tb/tb_long_branch_unit.sv
module tb_long_branch_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [127:0] bundle = '0;
  logic [63:0] cur_ip = '0, pred = '0;
  logic [63:0] phys_mask = 64'hFFFF_0000_0000_0000;
  logic [63:0] virt_mask = 64'hFFF8_0000_0000_0000;
  logic [1:0] cur_slot = '0;
  logic xlate_on = 1'b0, trace_br = 1'b0, step_en = 1'b0;
  logic done, illegal_op, update, taken, br_we;
  logic [63:0] next_ip, br_data;
  logic [1:0] next_slot, exc_code;
  logic [2:0] br_sel;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  long_branch_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bundle(bundle), .cur_ip(cur_ip),
    .cur_slot(cur_slot), .pred(pred), .phys_mask(phys_mask), .virt_mask(virt_mask),
    .xlate_on(xlate_on), .trace_br(trace_br), .step_en(step_en), .done(done),
    .illegal_op(illegal_op), .update(update), .taken(taken), .next_ip(next_ip),
    .next_slot(next_slot), .br_we(br_we), .br_sel(br_sel), .br_data(br_data),
    .exc_code(exc_code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] enc(input logic [3:0] op, input logic [2:0] rs,
                                       input logic [5:0] qp, input logic [63:0] off);
    logic [127:0] b = '0;
    b[127:124] = op;
    b[95:93]   = rs;
    b[92:87]   = qp;
    b[123]     = off[63];
    b[86:64]   = off[62:40];
    b[63:48]   = off[39:24];
    b[119:100] = off[23:4];
    b[4:0]     = 5'h04;
    return b;
  endfunction

  task automatic fire(input logic [127:0] b, input logic [63:0] ip, input logic [1:0] sl,
                      input logic [63:0] pr, input logic it, input logic tb, input logic ss);
    @(negedge clk);
    bundle = b; cur_ip = ip; cur_slot = sl; pred = pr;
    xlate_on = it; trace_br = tb; step_en = ss; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_illegal(input string req);
    chk({req, " done"}, 64'(done), 64'd1);
    chk({req, " illegal_op"}, 64'(illegal_op), 64'd1);
    chk({req, " quiet"}, {61'd0, update, taken, br_we}, 64'd0);
    chk({req, " exc R12"}, 64'(exc_code), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 outputs", {58'd0, done, illegal_op, update, taken, br_we, |exc_code}, 64'd0);
  endtask

  task automatic t_gate;
    logic [127:0] b = enc(4'hC, 3'd0, 6'd0, 64'h100);
    fire(b, 64'h1000, 2'd0, 64'h1, 0, 0, 0); expect_illegal("R3 slot0");
    fire(b, 64'h1000, 2'd2, 64'h1, 0, 0, 0); expect_illegal("R3 slot2");
    b[4:0] = 5'h06;
    fire(b, 64'h1000, 2'd1, 64'h1, 0, 0, 0); expect_illegal("R3 template");
    b[4:0] = 5'h05;
    fire(b, 64'h1000, 2'd1, 64'h1, 0, 0, 0);
    chk("R3 bit0 ignored", 64'(illegal_op), 64'd0);
    chk("R3 bit0 ignored ip", next_ip, 64'h1100);
  endtask

  task automatic t_opcode;
    fire(enc(4'hE, 3'd0, 6'd0, 64'h100), 64'h1000, 2'd1, 64'h1, 0, 1, 0);
    expect_illegal("R4 opE");
    fire(enc(4'hC, 3'd1, 6'd0, 64'h100), 64'h1000, 2'd1, 64'h1, 0, 1, 1);
    expect_illegal("R4 br rsel1 R12");
  endtask

  task automatic t_branch;
    logic [63:0] off = 64'hFFFF_FFFF_FFFF_FF00;
    fire(enc(4'hC, 3'd0, 6'd63, off), 64'h1000, 2'd1, 64'h8000_0000_0000_0000, 0, 0, 0);
    chk("R7 taken", 64'(taken), 64'd1);
    chk("R5 R7 ip neg off", next_ip, 64'h0F00);
    chk("R7 slot", 64'(next_slot), 64'd0);
    chk("R8 br no write", 64'(br_we), 64'd0);
    chk("R11 none", 64'(exc_code), 64'd0);
    @(negedge clk);
    chk("R2 one cycle", {61'd0, done, update, taken}, 64'd0);
    fire(enc(4'hC, 3'd0, 6'd5, 64'h0000_00AB_CDEF_1230), 64'h40, 2'd1, 64'h20, 0, 0, 0);
    chk("R5 mixed fields", next_ip, 64'h0000_00AB_CDEF_1270);
  endtask

  task automatic t_raw_field;
    logic [127:0] b = enc(4'hC, 3'd0, 6'd2, 64'h0);
    b[48] = 1'b1;
    fire(b, 64'h10, 2'd1, 64'h4, 0, 0, 0);
    chk("R5 low word field", next_ip, 64'h0100_0010);
    b = enc(4'hC, 3'd0, 6'd2, 64'h0);
    b[100] = 1'b1;
    fire(b, 64'h10, 2'd1, 64'h4, 0, 0, 0);
    chk("R5 high word field", next_ip, 64'h20);
  endtask

  task automatic t_call;
    fire(enc(4'hD, 3'd5, 6'd9, 64'h2000), 64'h3000, 2'd1, 64'h200, 0, 0, 0);
    chk("R8 we", 64'(br_we), 64'd1);
    chk("R8 sel", 64'(br_sel), 64'd5);
    chk("R8 data", br_data, 64'h3010);
    chk("R7 call ip", next_ip, 64'h5000);
    fire(enc(4'hD, 3'd7, 6'd1, 64'h10), 64'h100, 2'd1, 64'h2, 0, 0, 0);
    chk("R8 sel7", 64'(br_sel), 64'd7);
  endtask

  task automatic t_pred_false;
    fire(enc(4'hD, 3'd2, 6'd9, 64'h2000), 64'h3000, 2'd1, ~64'h200, 0, 1, 1);
    chk("R6 ip", next_ip, 64'h3010);
    chk("R6 flags", {60'd0, update, taken, br_we, done}, 64'b1001);
    chk("R6 exc", 64'(exc_code), 64'd0);
  endtask

  task automatic t_phys;
    fire(enc(4'hC, 3'd0, 6'd0, 64'h0000_FFFF_FFFF_F000), 64'h1000, 2'd1, 64'h1, 0, 1, 1);
    chk("R9 bit48 R11 prio", 64'(exc_code), 64'd1);
    fire(enc(4'hC, 3'd0, 6'd0, 64'h0000_FFFF_FFFF_E000), 64'h1000, 2'd1, 64'h1, 0, 0, 0);
    chk("R9 in range", 64'(exc_code), 64'd0);
  endtask

  task automatic t_virt;
    fire(enc(4'hC, 3'd0, 6'd0, 64'hFFFF_FFFF_FFFF_0000), 64'h0, 2'd1, 64'h1, 1, 0, 0);
    chk("R10 all ones ok", 64'(exc_code), 64'd0);
    fire(enc(4'hC, 3'd0, 6'd0, 64'h0008_0000_0000_0000), 64'h0, 2'd1, 64'h1, 1, 0, 0);
    chk("R10 top bit only bad", 64'(exc_code), 64'd1);
    fire(enc(4'hC, 3'd0, 6'd0, 64'h0004_0000_0000_0000), 64'h0, 2'd1, 64'h1, 1, 0, 1);
    chk("R10 below mask ok R11 step", 64'(exc_code), 64'd3);
    fire(enc(4'hC, 3'd0, 6'd0, 64'hFFF0_0000_0000_0000), 64'h0, 2'd1, 64'h1, 0, 0, 0);
    chk("R9 phys same target bad", 64'(exc_code), 64'd1);
  endtask

  task automatic t_prio;
    fire(enc(4'hC, 3'd0, 6'd0, 64'h40), 64'h0, 2'd1, 64'h1, 0, 1, 1);
    chk("R11 trace over step", 64'(exc_code), 64'd2);
    fire(enc(4'hC, 3'd0, 6'd0, 64'h40), 64'h0, 2'd1, 64'h1, 0, 0, 1);
    chk("R11 step", 64'(exc_code), 64'd3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_gate();
    t_opcode();
    t_branch();
    t_raw_field();
    t_call();
    t_pred_false();
    t_phys();
    t_virt();
    t_prio();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule